// File: doc/BRIEF.md
# Pre-Decoded Instruction Record Cache with Page Write Stamps

This block keeps pre-decoded instruction records in a direct-mapped array. The array is indexed by the low bits of the physical fetch address. Each slot holds the full physical address it was filled for, a stamp, and a payload of fixed width. A second table holds one stamp per 4 KB page. That stamp is made of a write counter in its low bits and a group of fetch-mode bits above it. A slot stays usable only while its stamp equals the stamp of its page.

A lookup carries an address and a fetch-mode mask, and the answer appears in the following cycle. On a miss the slot is allocated at once. The page's mode bits are overwritten with the requester's mask, and the slot takes the address and the merged page stamp. The block then waits until the decoder either delivers the payload or reports that decoding failed. A failure poisons the slot with the all-ones stamp. Any store to a page advances that page's counter, so every record already cached for the page goes stale. The counter saturates at its maximum, and a page whose counter has saturated is never served from the cache.

The controller has three states, and R2 and R10 describe its timing and the point at which it takes requests.
- IDLE accepts a lookup and moves to PROBE.
- PROBE presents the result. On a hit it returns to IDLE. On a miss it allocates the slot and moves to WAIT.
- WAIT returns to IDLE on a fill or on a decode failure.

Top module: `dic_cache`

## Requirements
- R1: After reset the block is in IDLE with `lookup_ready` high and `resp_valid` low. Every slot stamp is all ones and every page stamp is zero, so a lookup misses until its slot has been filled.
- R2: A lookup accepted at a clock edge (`lookup_valid` and `lookup_ready` both high) raises `resp_valid` for exactly the following cycle. `resp_hit` and `resp_payload` are valid in that cycle.
- R3: After a miss, `fill_valid` in WAIT stores `fill_payload` into the slot. A later lookup with the same address and mode then hits and returns that payload.
- R4: The slot index is `addr[IDX_W-1:0]`. A lookup whose address differs from the stored address in the same slot misses, and its fill evicts the earlier record.
- R5: A store (`store_valid`) advances the counter of page `store_addr[PADDR_W-1:12]`. Records already cached for that page then miss. Records of other pages keep hitting.
- R6: A hit requires that every bit set in `lookup_mode` is also set in the page's mode bits. A mask that is a subset of those bits hits, and one with an extra bit misses.
- R7: A miss replaces the page's mode bits with the requester's mask and keeps its counter. Records filled for that page under a different mask then miss whatever mask is used.
- R8: `fail_valid` in WAIT returns to IDLE and poisons the slot. The slot misses until it is filled by a later miss.
- R9: A page counter of CNT_W bits stops at all ones and never wraps. While a page's counter is saturated, lookups to that page miss even right after a fill.
- R10: While `lookup_ready` is low (PROBE or WAIT), `lookup_valid` is ignored and no response is produced for it.
- R11: A store to the page of a slot that is waiting for its fill makes that slot miss after the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookup_valid | input | 1 | Lookup request |
| lookup_addr | input | PADDR_W | Physical fetch address |
| lookup_mode | input | MODE_W | Current fetch-mode mask |
| lookup_ready | output | 1 | High in IDLE; lookups are taken only then |
| resp_valid | output | 1 | Result of the previous cycle's lookup |
| resp_hit | output | 1 | Result is a usable record |
| resp_payload | output | PAYLOAD_W | Cached record on a hit |
| fill_valid | input | 1 | Decoder delivers the record for the pending miss |
| fill_payload | input | PAYLOAD_W | Decoded record |
| fail_valid | input | 1 | Decoding of the pending miss failed |
| store_valid | input | 1 | A store was made to memory |
| store_addr | input | PADDR_W | Physical address of that store |

## Verification
The embedded properties watch every cycle for the following:
- the one-cycle request-to-response relation;
- the move out of PROBE on a hit and on a miss;
- a page counter that moves on every non-saturated store and never wraps from all ones back to zero.

The bench's scenarios have to show the rest, because it depends on sequences of operations. Those are stale records after stores, the subset rule for mode masks, and mode replacement on allocation. They also include eviction by a conflicting address, poisoning after a decode failure, the saturated-page rule, and the effect of a store that arrives while a fill is pending.

// File: rtl/dic_pkg.sv
`timescale 1ns/1ps
package dic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_WAIT  = 2'd2
    } dic_state_e;
endpackage

// File: rtl/dic_page_stamps.sv
`timescale 1ns/1ps
module dic_page_stamps #(
    parameter int PADDR_W = 20,
    parameter int CNT_W   = 29,
    parameter int MODE_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PADDR_W-13:0]      rd_pg,
    output logic [CNT_W-1:0]         rd_cnt,
    output logic [MODE_W-1:0]        rd_mode,
    input  logic                     bump_en,
    input  logic [PADDR_W-13:0]      bump_pg,
    input  logic                     mark_en,
    input  logic [PADDR_W-13:0]      mark_pg,
    input  logic [MODE_W-1:0]        mark_mode
);
    localparam int PG_W = PADDR_W - 12;
    localparam int NPG  = 1 << PG_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt_q  [NPG];
    logic [MODE_W-1:0] mode_q [NPG];
    logic [CNT_W-1:0]  bump_cnt;
    logic [CNT_W-1:0]  bump_next;

    assign rd_cnt    = cnt_q[rd_pg];
    assign rd_mode   = mode_q[rd_pg];
    assign bump_cnt  = cnt_q[bump_pg];
    assign bump_next = (bump_cnt == CNT_MAX) ? bump_cnt : bump_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPG; i++) begin
                cnt_q[i]  <= '0;
                mode_q[i] <= '0;
            end
        end else begin
            if (bump_en) cnt_q[bump_pg]  <= bump_next;
            if (mark_en) mode_q[mark_pg] <= mark_mode;
        end
    end

    // R5: a store to a non-saturated page changes its counter
    assert_cnt_advances_R5: assert property (@(posedge clk) disable iff (rst)
        (bump_en && bump_cnt != CNT_MAX) |=> cnt_q[$past(bump_pg)] != $past(bump_cnt));

    // R9: a saturated counter never wraps to zero
    assert_cnt_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (bump_en && bump_cnt == CNT_MAX) |=> cnt_q[$past(bump_pg)] != '0);
endmodule

// File: rtl/dic_entry_ram.sv
`timescale 1ns/1ps
module dic_entry_ram #(
    parameter int PADDR_W   = 20,
    parameter int IDX_W     = 10,
    parameter int STAMP_W   = 32,
    parameter int PAYLOAD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     idx,
    output logic [PADDR_W-1:0]   rd_tag,
    output logic [STAMP_W-1:0]   rd_stamp,
    output logic [PAYLOAD_W-1:0] rd_payload,
    input  logic                 alloc_en,
    input  logic [PADDR_W-1:0]   alloc_tag,
    input  logic [STAMP_W-1:0]   alloc_stamp,
    input  logic                 kill_en,
    input  logic                 fill_en,
    input  logic [PAYLOAD_W-1:0] fill_payload
);
    localparam int NENT = 1 << IDX_W;
    localparam logic [STAMP_W-1:0] STAMP_DEAD = {STAMP_W{1'b1}};

    logic [PADDR_W-1:0]   tag_q   [NENT];
    logic [STAMP_W-1:0]   stamp_q [NENT];
    logic [PAYLOAD_W-1:0] pay_q   [NENT];

    assign rd_tag     = tag_q[idx];
    assign rd_stamp   = stamp_q[idx];
    assign rd_payload = pay_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) stamp_q[i] <= STAMP_DEAD;
        end else if (kill_en) begin
            stamp_q[idx] <= STAMP_DEAD;
        end else if (alloc_en) begin
            stamp_q[idx] <= alloc_stamp;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) tag_q[idx] <= alloc_tag;
        if (fill_en)  pay_q[idx] <= fill_payload;
    end
endmodule

// File: rtl/dic_cache.sv
`timescale 1ns/1ps
module dic_cache
    import dic_pkg::*;
#(
    parameter int PADDR_W   = 20,
    parameter int IDX_W     = 10,
    parameter int PAYLOAD_W = 16,
    parameter int CNT_W     = 29,
    parameter int MODE_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lookup_valid,
    input  logic [PADDR_W-1:0]   lookup_addr,
    input  logic [MODE_W-1:0]    lookup_mode,
    output logic                 lookup_ready,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [PAYLOAD_W-1:0] resp_payload,
    input  logic                 fill_valid,
    input  logic [PAYLOAD_W-1:0] fill_payload,
    input  logic                 fail_valid,
    input  logic                 store_valid,
    input  logic [PADDR_W-1:0]   store_addr
);
    localparam int STAMP_W = CNT_W + MODE_W;
    localparam logic [STAMP_W-1:0] STAMP_DEAD = {STAMP_W{1'b1}};
    localparam logic [CNT_W-1:0]   CNT_MAX    = {CNT_W{1'b1}};

    dic_state_e state_q, state_d;
    logic [PADDR_W-1:0] req_addr_q;
    logic [MODE_W-1:0]  req_mode_q;

    logic [CNT_W-1:0]     pg_cnt;
    logic [MODE_W-1:0]    pg_mode;
    logic [PADDR_W-1:0]   ent_tag;
    logic [STAMP_W-1:0]   ent_stamp;
    logic [PAYLOAD_W-1:0] ent_payload;
    logic                 hit_w;
    logic                 alloc_en, fill_en, kill_en;

    dic_page_stamps #(.PADDR_W(PADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W)) u_pages (
        .clk       (clk),
        .rst       (rst),
        .rd_pg     (req_addr_q[PADDR_W-1:12]),
        .rd_cnt    (pg_cnt),
        .rd_mode   (pg_mode),
        .bump_en   (store_valid),
        .bump_pg   (store_addr[PADDR_W-1:12]),
        .mark_en   (alloc_en),
        .mark_pg   (req_addr_q[PADDR_W-1:12]),
        .mark_mode (req_mode_q)
    );

    dic_entry_ram #(.PADDR_W(PADDR_W), .IDX_W(IDX_W), .STAMP_W(STAMP_W),
                    .PAYLOAD_W(PAYLOAD_W)) u_entries (
        .clk          (clk),
        .rst          (rst),
        .idx          (req_addr_q[IDX_W-1:0]),
        .rd_tag       (ent_tag),
        .rd_stamp     (ent_stamp),
        .rd_payload   (ent_payload),
        .alloc_en     (alloc_en),
        .alloc_tag    (req_addr_q),
        .alloc_stamp  ({req_mode_q, pg_cnt}),
        .kill_en      (kill_en),
        .fill_en      (fill_en),
        .fill_payload (fill_payload)
    );

    // hit: tag, stamp and mode-subset all agree, slot alive, page not saturated
    always_comb begin
        hit_w = (ent_tag == req_addr_q)
             && (ent_stamp == {pg_mode, pg_cnt})
             && ((pg_mode & req_mode_q) == req_mode_q)
             && (ent_stamp != STAMP_DEAD)
             && (pg_cnt != CNT_MAX);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_addr_q <= '0;
            req_mode_q <= '0;
        end else if (state_q == ST_IDLE && lookup_valid) begin
            req_addr_q <= lookup_addr;
            req_mode_q <= lookup_mode;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (lookup_valid) state_d = ST_PROBE;
            ST_PROBE: state_d = hit_w ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (fill_valid || fail_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and array strobes
    always_comb begin
        lookup_ready = (state_q == ST_IDLE);
        resp_valid   = (state_q == ST_PROBE);
        resp_hit     = (state_q == ST_PROBE) && hit_w;
        resp_payload = ent_payload;
        alloc_en     = (state_q == ST_PROBE) && !hit_w;
        kill_en      = (state_q == ST_WAIT) && fail_valid;
        fill_en      = (state_q == ST_WAIT) && fill_valid && !fail_valid;
    end

    assert_resp_after_req_R2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(lookup_valid && lookup_ready));

    assert_busy_while_resp_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !lookup_ready);

    assert_hit_returns_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |=> (lookup_ready && !resp_valid));

    assert_miss_waits_R3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |=> (!lookup_ready && !resp_valid));
endmodule

// File: tb/dic_cache_bench.sv
`timescale 1ns/1ps
module dic_cache_bench;
    localparam int AW = 16;
    localparam int PW = 8;
    localparam int MW = 3;
    localparam int OP_LOOK = 0;
    localparam int OP_FAIL = 1;
    localparam int OP_STORE = 2;
    localparam int NV = 19;

    // {req[3:0], op[1:0], addr[15:0], mode[2:0], exp_hit, payload[7:0]}
    localparam logic [33:0] VEC [NV] = '{
        {4'd1, 2'd0, 16'h1004, 3'b001, 1'b0, 8'hA1},
        {4'd3, 2'd0, 16'h1004, 3'b001, 1'b1, 8'hA1},
        {4'd4, 2'd0, 16'h2004, 3'b001, 1'b0, 8'hB2},
        {4'd4, 2'd0, 16'h1004, 3'b001, 1'b0, 8'hA1},
        {4'd3, 2'd0, 16'h1008, 3'b001, 1'b0, 8'hC3},
        {4'd5, 2'd2, 16'h3000, 3'b000, 1'b0, 8'h00},
        {4'd5, 2'd0, 16'h1008, 3'b001, 1'b1, 8'hC3},
        {4'd5, 2'd2, 16'h1FFF, 3'b000, 1'b0, 8'h00},
        {4'd5, 2'd0, 16'h1008, 3'b001, 1'b0, 8'hC4},
        {4'd5, 2'd0, 16'h1004, 3'b001, 1'b0, 8'hA5},
        {4'd6, 2'd0, 16'h1004, 3'b000, 1'b1, 8'hA5},
        {4'd6, 2'd0, 16'h1004, 3'b011, 1'b0, 8'hA6},
        {4'd6, 2'd0, 16'h1004, 3'b001, 1'b1, 8'hA6},
        {4'd7, 2'd0, 16'h1008, 3'b001, 1'b0, 8'hC7},
        {4'd7, 2'd0, 16'h1004, 3'b011, 1'b0, 8'hA8},
        {4'd7, 2'd0, 16'h1004, 3'b011, 1'b1, 8'hA8},
        {4'd8, 2'd1, 16'h2008, 3'b001, 1'b0, 8'h00},
        {4'd8, 2'd0, 16'h2008, 3'b001, 1'b0, 8'hD1},
        {4'd8, 2'd0, 16'h2008, 3'b001, 1'b1, 8'hD1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lookup_valid = 1'b0;
    logic [AW-1:0] lookup_addr = '0;
    logic [MW-1:0] lookup_mode = '0;
    logic lookup_ready, resp_valid, resp_hit;
    logic [PW-1:0] resp_payload;
    logic fill_valid = 1'b0;
    logic [PW-1:0] fill_payload = '0;
    logic fail_valid = 1'b0;
    logic store_valid = 1'b0;
    logic [AW-1:0] store_addr = '0;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dic_cache #(.PADDR_W(AW), .IDX_W(4), .PAYLOAD_W(PW), .CNT_W(4), .MODE_W(MW)) u_dic_cache (
        .clk(clk), .rst(rst),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr), .lookup_mode(lookup_mode),
        .lookup_ready(lookup_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_payload(resp_payload), .fill_valid(fill_valid), .fill_payload(fill_payload),
        .fail_valid(fail_valid), .store_valid(store_valid), .store_addr(store_addr)
    );

    function automatic string rtag(input int n);
        case (n)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic [MW-1:0] m,
                          output logic h, output logic [PW-1:0] p);
        @(negedge clk);
        while (!lookup_ready) @(negedge clk);
        lookup_valid = 1'b1; lookup_addr = a; lookup_mode = m;
        @(negedge clk);
        lookup_valid = 1'b0;
        check("R2", "resp_valid one cycle after request", int'(resp_valid), 1);
        h = resp_hit; p = resp_payload;
    endtask

    task automatic fill(input logic [PW-1:0] p);
        @(negedge clk);
        fill_valid = 1'b1; fill_payload = p;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic fail_decode();
        @(negedge clk);
        fail_valid = 1'b1;
        @(negedge clk);
        fail_valid = 1'b0;
    endtask

    task automatic store(input logic [AW-1:0] a);
        @(negedge clk);
        store_valid = 1'b1; store_addr = a;
        @(negedge clk);
        store_valid = 1'b0;
    endtask

    // lookup, check hit flag and (on hit) payload; complete a miss with a fill
    task automatic probe(input string req, input logic [AW-1:0] a, input logic [MW-1:0] m,
                         input bit exp_hit, input logic [PW-1:0] pay);
        logic h;
        logic [PW-1:0] p;
        lookup(a, m, h, p);
        check(req, $sformatf("hit at %h mode %b", a, m), int'(h), int'(exp_hit));
        if (h) check(req, "payload", int'(p), int'(pay));
        else   fill(pay);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic h;
        logic [PW-1:0] p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "ready after reset", int'(lookup_ready), 1);
        check("R1", "no response after reset", int'(resp_valid), 0);

        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            if (int'(v[29:28]) == OP_STORE) begin
                store(v[27:12]);
            end else if (int'(v[29:28]) == OP_FAIL) begin
                lookup(v[27:12], v[11:9], h, p);
                check(rtag(int'(v[33:30])), $sformatf("row %0d miss", i), int'(h), 0);
                fail_decode();
                @(negedge clk);
                check("R8", "ready after decode failure", int'(lookup_ready), 1);
            end else begin
                probe(rtag(int'(v[33:30])), v[27:12], v[11:9], v[8], v[7:0]);
            end
        end

        // R2: response lasts one cycle only
        lookup(16'h2008, 3'b001, h, p);
        @(negedge clk);
        check("R2", "resp_valid drops after one cycle", int'(resp_valid), 0);

        // R10 and R11: requests while waiting
        lookup(16'h4001, 3'b000, h, p);
        check("R10", "fresh page miss", int'(h), 0);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_addr = 16'h4001;
        store_valid = 1'b1; store_addr = 16'h4000;
        @(negedge clk);
        lookup_valid = 1'b0; store_valid = 1'b0;
        check("R10", "ignored lookup gives no response", int'(resp_valid), 0);
        check("R10", "still waiting", int'(lookup_ready), 0);
        fill(8'hE1);
        check("R10", "no late response", int'(resp_valid), 0);
        probe("R11", 16'h4001, 3'b000, 1'b0, 8'hE2);
        probe("R11", 16'h4001, 3'b000, 1'b1, 8'hE2);

        // R9: saturation on page 5 (CNT_W = 4 in this bench)
        for (int k = 0; k < 14; k++) store(16'h5000);
        probe("R9", 16'h5002, 3'b001, 1'b0, 8'hF1);
        probe("R9", 16'h5002, 3'b001, 1'b1, 8'hF1);
        store(16'h5000);
        probe("R9", 16'h5002, 3'b001, 1'b0, 8'hF2);
        probe("R9", 16'h5002, 3'b001, 1'b0, 8'hF2);
        store(16'h5000);
        probe("R9", 16'h5002, 3'b001, 1'b0, 8'hF3);
        probe("R9", 16'h5002, 3'b001, 1'b0, 8'hF3);

        // R1: reset in mid-run drops all records
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "ready after second reset", int'(lookup_ready), 1);
        probe("R1", 16'h1004, 3'b011, 1'b0, 8'h11);
        probe("R1", 16'h1004, 3'b011, 1'b1, 8'h11);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule